// File: doc/BRIEF.md
# Zero-Crossing Terminated One-Shot Pulse Timer

This block produces one gate pulse for every cycle of an upstream oscillator. A single-cycle trigger starts the pulse. A cycle counter then stands in for the timing ramp: it restarts from zero on every accepted trigger and counts the clock cycles the pulse has been high. Two threshold inputs bound the width. The lower threshold opens a blanking window. During that window a zero-detect level is ignored, which guarantees a minimum on-time. Once the window has closed, the first synchronized zero-detect ends the pulse early. If no zero-detect arrives, the pulse stops when the upper threshold is reached. Typical settings keep the upper threshold at about four times the lower one.

The zero-detect input is treated as asynchronous and passes through a two-stage synchronizer. An enable input acts as a fault or lockout gate. When enable is low the pulse output drops in the same cycle and the timer returns to idle. Every normal end of a pulse, whether it is cut short or timed out, is marked by a one-cycle strobe.

The controller has three states. `ST_IDLE` is the rest state. `ST_BLANK` means the pulse is high and zero-detect is masked. `ST_ARMED` means the pulse is high and zero-detect is honoured. The transitions are:
- START: from `ST_IDLE`, on a trigger with enable high. The timer enters `ST_ARMED` directly when the lower threshold is 1 or less; otherwise it enters `ST_BLANK`.
- UNBLANK: from `ST_BLANK` to `ST_ARMED` when the next pulse cycle reaches the lower threshold.
- TIMEOUT: from `ST_BLANK` or `ST_ARMED` to `ST_IDLE` when the upper threshold is reached.
- CUT: from `ST_ARMED` to `ST_IDLE` on a synchronized zero-detect.
- ABORT: from any active state to `ST_IDLE` when enable is low.

Top module: `zc_oneshot`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released, `pulse_o` and `done_o` are low whatever `trig` does.
- R2: When `trig` is sampled high at a rising edge while the timer is idle and `en` is high, `pulse_o` is high from the following cycle on.
- R3: With no zero-detect, the pulse stays high for exactly `max_cnt` cycles; a value of 0 acts as 1.
- R4: Pulse cycles are numbered k = 1, 2, ... A zero-detect seen in any pulse cycle with k below `min_cnt` has no effect. If `zero_det` is held high across the trigger, the pulse width is `min_cnt` cycles, with a floor of 1, provided that value does not exceed `max_cnt`.
- R5: After the blanking window, the pulse ends after the first pulse cycle k, with k at least `min_cnt`, in which the synchronized zero-detect is high. `zero_det` sampled high at edge number j, where the trigger edge is number 0, is seen in pulse cycle j+2.
- R6: When `min_cnt` is at least `max_cnt`, the upper threshold wins and the width is `max_cnt`.
- R7: A trigger that arrives while a pulse is high is ignored. It neither restarts the count nor starts a second pulse.
- R8: When `en` is low, `pulse_o` is low in the same cycle. The pulse does not resume when `en` returns, no `done_o` is issued for it, and a trigger seen with `en` low is ignored.
- R9: `done_o` is high for exactly one cycle, the first cycle after `pulse_o` falls, for both a timeout and a cut.
- R10: A trigger accepted in the `done_o` cycle starts a new pulse immediately. The count restarts from zero, so the new width matches the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces the pulse off (fault or lockout) |
| trig | input | 1 | Start-of-cycle trigger from the oscillator |
| zero_det | input | 1 | Asynchronous zero-crossing level from the comparator |
| min_cnt | input | CW | Lower threshold: the blanking length in cycles |
| max_cnt | input | CW | Upper threshold: the maximum width in cycles |
| pulse_o | output | 1 | Gate pulse |
| done_o | output | 1 | One-cycle end-of-pulse strobe |

## Verification
The bench places zero-detect edges around the boundary of the blanking window. It raises zero-detect before the trigger, on the trigger edge, just before the window closes and after the upper threshold. A design that drops the synchronizer latency or lets blanking end one cycle off would then give widths one or two cycles wrong. Inverted thresholds and a lower threshold of 0 test whether the timeout takes priority and whether a one-cycle floor exists. Retriggers in mid-pulse, a trigger in the strobe cycle and an enable drop inside a pulse expose a design that restarts its count, loses back-to-back pulses, or resumes the pulse or strobes after an abort.

// File: rtl/zc_oneshot_pkg.sv
package zc_oneshot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ARMED = 2'd2
    } os_state_t;
endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[STAGES-2:0], d};
            end
            assign q = s_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/zc_width_cnt.sv
module zc_width_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] min_cnt,
    input  logic [CW-1:0] max_cnt,
    output logic          at_max,
    output logic          min_next,
    output logic          min_first
);
    localparam int KW = CW + 1;
    localparam int NW = CW + 2;

    logic [CW-1:0] cnt_q;
    logic [KW-1:0] k_cur;
    logic [NW-1:0] k_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clr)                  cnt_q <= '0;
        else if (inc && !(&cnt_q))     cnt_q <= cnt_q + CW'(1);
    end

    // k_cur is the 1-based index of the pulse cycle in progress
    always_comb begin
        k_cur     = {1'b0, cnt_q} + KW'(1);
        k_nxt     = {1'b0, k_cur} + NW'(1);
        at_max    = (k_cur >= {1'b0, max_cnt});
        min_next  = (k_nxt >= {2'b00, min_cnt});
        min_first = (min_cnt <= CW'(1));
    end
endmodule

// File: rtl/zc_os_fsm.sv
module zc_os_fsm
    import zc_oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic trig,
    input  logic zs,
    input  logic at_max,
    input  logic min_next,
    input  logic min_first,
    output logic active,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic done
);
    os_state_t state_q, state_d;
    logic      fin;
    logic      done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en && trig) state_d = min_first ? ST_ARMED : ST_BLANK;
            end
            ST_BLANK: begin
                if (!en)           state_d = ST_IDLE;
                else if (at_max)   state_d = ST_IDLE;
                else if (min_next) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en)               state_d = ST_IDLE;
                else if (at_max || zs) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active  = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = en && trig;
            end
            ST_BLANK: begin
                active  = 1'b1;
                fin     = en && at_max;
                cnt_inc = en && !at_max;
            end
            ST_ARMED: begin
                active  = 1'b1;
                fin     = en && (at_max || zs);
                cnt_inc = en && !(at_max || zs);
            end
            default: begin
                active = 1'b0;
            end
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/zc_oneshot.sv
module zc_oneshot #(
    parameter int CW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          trig,
    input  logic          zero_det,
    input  logic [CW-1:0] min_cnt,
    input  logic [CW-1:0] max_cnt,
    output logic          pulse_o,
    output logic          done_o
);
    logic zs;
    logic at_max, min_next, min_first;
    logic active, cnt_clr, cnt_inc;

    zc_sync #(.STAGES(SYNC_STGS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (zero_det),
        .q     (zs)
    );

    zc_width_cnt #(.CW(CW)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .min_cnt   (min_cnt),
        .max_cnt   (max_cnt),
        .at_max    (at_max),
        .min_next  (min_next),
        .min_first (min_first)
    );

    zc_os_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .trig      (trig),
        .zs        (zs),
        .at_max    (at_max),
        .min_next  (min_next),
        .min_first (min_first),
        .active    (active),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .done      (done_o)
    );

    // enable gates the pulse combinationally so a fault removes it at once
    assign pulse_o = active & en;
endmodule

// File: rtl/zc_oneshot_chk.sv
module zc_oneshot_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          trig,
    input logic [CW-1:0] min_cnt,
    input logic [CW-1:0] max_cnt,
    input logic          pulse_o,
    input logic          done_o
);
    localparam int WW = CW + 2;

    logic [WW-1:0] w_q;
    logic [WW-1:0] maxe;
    logic [WW-1:0] mine;
    logic [WW-1:0] lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       w_q <= '0;
        else if (pulse_o) w_q <= w_q + WW'(1);
        else              w_q <= '0;
    end

    always_comb begin
        maxe = (max_cnt == '0) ? WW'(1) : {2'b00, max_cnt};
        mine = (min_cnt == '0) ? WW'(1) : {2'b00, min_cnt};
        lo   = (mine < maxe) ? mine : maxe;
    end

    AST_START_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_o && en && trig) |=> (pulse_o || !en)); // R2
    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (w_q < maxe)); // R3
    AST_WIDTH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (w_q >= lo)); // R4
    AST_NO_STROBE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !done_o); // R8
    AST_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> !pulse_o); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!pulse_o && $past(pulse_o))); // R9
endmodule

bind zc_oneshot zc_oneshot_chk #(.CW(CW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .trig    (trig),
    .min_cnt (min_cnt),
    .max_cnt (max_cnt),
    .pulse_o (pulse_o),
    .done_o  (done_o)
);

// File: tb/zc_oneshot_tb.sv
module zc_oneshot_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NV = 11;
    localparam int NEVER = 255;
    localparam int HELD = -2;

    // columns: min, max, zero edge index (HELD = high before trigger), expected width, requirement
    localparam int VEC [NV][5] = '{
        '{4, 16, NEVER, 16, 3},  // R3 timeout
        '{4, 16, HELD,   4, 4},  // R4 blanking hides early zero
        '{4, 16, 5,      7, 5},  // R5 cut after sync latency
        '{4, 16, 0,      4, 4},  // R4 zero on trigger edge
        '{3, 12, 2,      4, 5},  // R5 first cycle past window
        '{10, 6, HELD,   6, 6},  // R6 inverted thresholds
        '{0, 5, HELD,    1, 4},  // R4 one-cycle floor
        '{2, 8, 10,      8, 3},  // R3 zero arrives too late
        '{1, 1, NEVER,   1, 3},  // R3 single-cycle pulse
        '{5, 20, 3,      5, 4},  // R4 zero exactly at window end
        '{6, 24, 12,    14, 5}   // R5 four-to-one setting
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic          trig = 1'b0;
    logic          zero_det = 1'b0;
    logic [CW-1:0] min_cnt = '0;
    logic [CW-1:0] max_cnt = '0;
    logic          pulse_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_oneshot #(.CW(CW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .trig     (trig),
        .zero_det (zero_det),
        .min_cnt  (min_cnt),
        .max_cnt  (max_cnt),
        .pulse_o  (pulse_o),
        .done_o   (done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_vec(input int mn, input int mx, input int d, input int exp_w, input int req);
        int w = 0;
        int done_at = -1;
        int done_n = 0;
        int lim = ((mx == 0) ? 1 : mx) + 4;
        @(negedge clk);
        min_cnt = CW'(mn);
        max_cnt = CW'(mx);
        zero_det = (d < 0);
        repeat (3) @(negedge clk);
        for (int m = 0; m <= lim; m++) begin
            if (m > 0) begin
                @(negedge clk);
                if (pulse_o) w++;
                if (done_o) begin
                    done_n++;
                    if (done_at < 0) done_at = m;
                end
            end
            trig = (m == 0);
            if (m == d) zero_det = 1'b1;
        end
        trig = 1'b0;
        zero_det = 1'b0;
        check(w == exp_w, $sformatf("R%0d width", req), w, exp_w);
        check(done_n == 1, "R9 strobe count", done_n, 1);
        check(done_at == exp_w + 1, "R9 strobe cycle", done_at, exp_w + 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int hi;
        int dn;
        // R1 reset state with trigger active
        trig = 1'b1;
        min_cnt = 8'd2;
        max_cnt = 8'd4;
        repeat (3) @(negedge clk);
        check(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
        check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
        trig = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pulse_o == 1'b0 && done_o == 1'b0, "R1 after release",
              int'({pulse_o, done_o}), 0);

        // R2 trigger starts pulse on next cycle
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check(pulse_o == 1'b1, "R2 start", int'(pulse_o), 1);
        repeat (8) @(negedge clk);

        for (int i = 0; i < NV; i++)
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

        // R7 retriggers mid-pulse are ignored
        min_cnt = 8'd2;
        max_cnt = 8'd10;
        hi = 0;
        dn = 0;
        for (int m = 0; m <= 18; m++) begin
            if (m > 0) begin
                @(negedge clk);
                hi += int'(pulse_o);
                dn += int'(done_o);
            end
            trig = (m == 0 || m == 3 || m == 5 || m == 9);
        end
        trig = 1'b0;
        check(hi == 10, "R7 width unchanged", hi, 10);
        check(dn == 1, "R7 single strobe", dn, 1);

        // R8 enable drop inside a pulse
        min_cnt = 8'd2;
        max_cnt = 8'd12;
        hi = 0;
        dn = 0;
        for (int m = 0; m <= 18; m++) begin
            if (m > 0) begin
                @(negedge clk);
                hi += int'(pulse_o);
                dn += int'(done_o);
            end
            trig = (m == 0);
            if (m == 4) begin
                en = 1'b0;
                #1;
                check(pulse_o == 1'b0, "R8 immediate off", int'(pulse_o), 0);
            end
            if (m == 6) en = 1'b1;
        end
        check(hi == 4, "R8 no resume", hi, 4);
        check(dn == 0, "R8 no strobe", dn, 0);

        // R8 trigger with enable low is ignored
        en = 1'b0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        en = 1'b1;
        hi = 0;
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            hi += int'(pulse_o);
        end
        check(hi == 0, "R8 trigger while off", hi, 0);

        // R10 back-to-back pulses, trigger in the strobe cycle
        min_cnt = 8'd3;
        max_cnt = 8'd6;
        hi = 0;
        dn = 0;
        for (int m = 0; m <= 17; m++) begin
            if (m > 0) begin
                @(negedge clk);
                hi += int'(pulse_o);
                dn += int'(done_o);
                if (m == 7) check(pulse_o == 1'b0 && done_o == 1'b1, "R10 gap cycle",
                                  int'({pulse_o, done_o}), 1);
                if (m == 8) check(pulse_o == 1'b1, "R10 restart", int'(pulse_o), 1);
                if (m == 14) check(done_o == 1'b1, "R10 second strobe", int'(done_o), 1);
            end
            trig = (m == 0 || m == 7);
        end
        trig = 1'b0;
        check(hi == 12, "R10 equal widths", hi, 12);
        check(dn == 2, "R10 strobes", dn, 2);

        finish_run();
    end
endmodule